// File: doc/BRIEF.md
# Operand-Size-Scaled Effective Address Unit

This block forms the byte address of a memory operand. The instruction carries a word address; the unit turns it into a byte address by placing two zero bits below it. When indexing is selected, the index value counts elements of the operand's size. It is scaled to a byte displacement by a left shift of 0, 1, 2 or 3 bits, for byte, half word, word or double word. The scaled index is then added to the byte base. The sum is 19 bits wide by default and wraps silently.

One request enters per accepted handshake on a valid/ready input. The result leaves one cycle later through a single valid/ready output register. The result carries the operand size and a flag that marks an address that is not a multiple of the operand size. Back-pressure works as follows. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, its contents stay frozen. A sender must hold its payload stable until it sees acceptance.

Top module: `opsz_ea_unit`

## Requirements
- R1: With indexing on and size code 00 (byte), the result is {word, 2'b00} + index, taken modulo 2^ADDR_W.
- R2: With indexing on and size code 01 (half word), the result is {word, 2'b00} + (index << 1), taken modulo 2^ADDR_W.
- R3: With indexing on and size code 10 (word), the result is {word, 2'b00} + (index << 2), taken modulo 2^ADDR_W.
- R4: With indexing on and size code 11 (double word), the result is {word, 2'b00} + (index << 3), taken modulo 2^ADDR_W.
- R5: With indexing off, the result is {word, 2'b00} whatever the index value.
- R6: A carry out of the top address bit is dropped, and no other output changes because of it.
- R7: out_misalign is 1 exactly when the low size-code bits of the result are not all zero (none for byte, bit 0 for half word, bits 1:0 for word, bits 2:0 for double word). Because of the scaling, it can only be 1 for a double word whose base word address is odd.
- R8: An accepted input (in_valid and in_ready high at a clock edge) appears on the outputs with out_valid high after that edge. A drained output (out_valid and out_ready high) with no new acceptance leaves out_valid low.
- R9: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_addr, out_size and out_misalign hold their values.
- R10: While rst_n is low at a clock edge, out_valid is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request will be taken at the next edge |
| in_word | input | ADDR_W-2 | Word address from the instruction |
| in_index | input | IDX_W | Index value, counted in operand elements |
| in_idx_en | input | 1 | 1 selects indexing, 0 ignores in_index |
| in_size | input | 2 | Operand size: 00 byte, 01 half, 10 word, 11 double |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result at the next edge |
| out_addr | output | ADDR_W | Byte address of the operand |
| out_size | output | 2 | Size code carried with the result |
| out_misalign | output | 1 | Result not a multiple of the operand size |

## Verification
The bench builds the unit with its defaults: a 19-bit byte address and a 19-bit index. With these values, a large index shifted by three places overflows the address width, so the wrap of R6 occurs both in the directed cases and often under random stimulus. All four shift amounts meet odd and even bases, so R7 can be reached. out_ready is throttled at random, which brings the R9 hold behaviour and simultaneous drain-and-refill into reach.

// File: rtl/opsz_ea_pkg.sv
package opsz_ea_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } opsz_e;

  localparam int SZ_COUNT = 4;
  localparam int SZ_LOW_W = 3;

  function automatic logic [SZ_LOW_W-1:0] low_mask(input opsz_e sz);
    logic [SZ_LOW_W-1:0] m;
    m = '0;
    for (int b = 0; b < SZ_LOW_W; b++) begin
      if (b < int'(sz)) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/opsz_ea_scale.sv
module opsz_ea_scale
  import opsz_ea_pkg::*;
#(
  parameter int IDX_W  = 19,
  parameter int ADDR_W = 19
) (
  input  logic [IDX_W-1:0]  index,
  input  logic              idx_en,
  input  opsz_e             size,
  output logic [ADDR_W-1:0] disp
);
  localparam int EXT_W = (IDX_W > ADDR_W) ? IDX_W : ADDR_W;

  logic [EXT_W-1:0]  ext;
  logic [ADDR_W-1:0] cand [SZ_COUNT];

  assign ext = EXT_W'(index);

  for (genvar g = 0; g < SZ_COUNT; g++) begin : g_shift
    logic [EXT_W-1:0] shifted;
    assign shifted = ext << g;
    assign cand[g] = shifted[ADDR_W-1:0];
  end

  always_comb begin
    disp = '0;
    if (idx_en) disp = cand[int'(size)];
  end
endmodule

// File: rtl/opsz_ea_sum.sv
module opsz_ea_sum
  import opsz_ea_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic [ADDR_W-3:0] word,
  input  logic [ADDR_W-1:0] disp,
  input  opsz_e             size,
  output logic [ADDR_W-1:0] addr,
  output logic              misalign
);
  logic [ADDR_W-1:0] base;

  assign base     = {word, 2'b00};
  assign addr     = base + disp;
  assign misalign = |(addr[SZ_LOW_W-1:0] & low_mask(size));
endmodule

// File: rtl/opsz_ea_stage.sv
module opsz_ea_stage #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign up_ready = !full_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) data_q <= up_data;
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/opsz_ea_unit.sv
module opsz_ea_unit
  import opsz_ea_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int IDX_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-3:0] in_word,
  input  logic [IDX_W-1:0]  in_index,
  input  logic              in_idx_en,
  input  logic [1:0]        in_size,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_size,
  output logic              out_misalign
);
  localparam int PAY_W = ADDR_W + 2 + 1;

  opsz_e             size;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] addr;
  logic              mis;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  assign size = opsz_e'(in_size);

  opsz_ea_scale #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_scale (
    .index (in_index),
    .idx_en(in_idx_en),
    .size  (size),
    .disp  (disp)
  );

  opsz_ea_sum #(.ADDR_W(ADDR_W)) u_sum (
    .word    (in_word),
    .disp    (disp),
    .size    (size),
    .addr    (addr),
    .misalign(mis)
  );

  assign pay_in = {addr, in_size, mis};

  opsz_ea_stage #(.DATA_W(PAY_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (pay_in),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (pay_out)
  );

  assign out_addr     = pay_out[PAY_W-1:3];
  assign out_size     = pay_out[2:1];
  assign out_misalign = pay_out[0];
endmodule

// File: rtl/opsz_ea_chk.sv
module opsz_ea_chk #(
  parameter int ADDR_W = 19,
  parameter int IDX_W  = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-3:0] in_word,
  input logic [IDX_W-1:0]  in_index,
  input logic              in_idx_en,
  input logic [1:0]        in_size,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_size,
  input logic              out_misalign
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_reset_empty_R10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_drain_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !acc |=> !out_valid);

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)
      && $stable(out_size) && $stable(out_misalign));

  assert_stalled_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_noindex_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_idx_en |=> out_addr == {$past(in_word), 2'b00});

  assert_byte_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_idx_en && in_size == 2'b00
      |=> out_addr == ADDR_W'({$past(in_word), 2'b00} + ADDR_W'($past(in_index))));

  assert_misalign_dword_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_misalign |-> out_size == 2'b11 && out_addr[2]);

  assert_size_carried_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_size == $past(in_size));

  wire unused_ok = &{1'b0, in_index[0]};
endmodule

bind opsz_ea_unit opsz_ea_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_word     (in_word),
  .in_index    (in_index),
  .in_idx_en   (in_idx_en),
  .in_size     (in_size),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_size    (out_size),
  .out_misalign(out_misalign)
);

// File: tb/sim_opsz_ea_unit.sv
module sim_opsz_ea_unit;
  localparam int ADDR_W = 19;
  localparam int IDX_W  = 19;
  localparam longint AMASK = (64'd1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ADDR_W-3:0] in_word = '0;
  logic [IDX_W-1:0]  in_index = '0;
  logic              in_idx_en = 1'b0;
  logic [1:0]        in_size = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [ADDR_W-1:0] out_addr;
  logic [1:0]        out_size;
  logic              out_misalign;

  always #2 clk = ~clk;

  opsz_ea_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // behavioural reference: one-entry holding register
  bit     m_valid = 0;
  longint m_addr, m_size;
  bit     m_mis, m_en, m_wrap;
  bit     m_acc = 0;

  always @(posedge clk) begin
    longint base, disp, sum;
    m_acc = 0;
    if (!rst_n) m_valid = 0;
    else if (in_valid && (!m_valid || out_ready)) begin
      base = longint'(in_word) * 4;
      disp = in_idx_en ? (longint'(in_index) << in_size) : 0;
      sum = base + disp;
      m_addr = sum & AMASK;
      m_wrap = (sum > AMASK);
      m_size = longint'(in_size);
      m_en = in_idx_en;
      m_mis = (m_addr % (longint'(1) << m_size)) != 0;
      m_valid = 1;
      m_acc = 1;
    end else if (out_ready) m_valid = 0;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic string addr_tag();
    if (!m_en) return "R5";
    if (m_wrap) return "R6";
    case (m_size)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic compare();
    if (!rst_n) chk("R10 out_valid in reset", longint'(out_valid), 0);
    else begin
      chk("R8 out_valid", longint'(out_valid), longint'(m_valid));
      chk("R9 in_ready", longint'(in_ready), longint'(!m_valid || out_ready));
      if (m_valid) begin
        chk(addr_tag(), longint'(out_addr), m_addr);
        chk("R7 misalign", longint'(out_misalign), longint'(m_mis));
        chk("R8 size", longint'(out_size), m_size);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic send(input longint w, input longint ix, input bit en, input int sz);
    in_valid = 1; in_word = (ADDR_W-2)'(w); in_index = IDX_W'(ix);
    in_idx_en = en; in_size = 2'(sz); out_ready = 1;
    step();
    in_valid = 0;
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    send(17'h00010, 5, 1, 0);           // R1
    send(17'h00010, 5, 1, 1);           // R2
    send(17'h00010, 5, 1, 2);           // R3
    send(17'h00010, 5, 1, 3);           // R4
    send(17'h00011, 2, 1, 3);           // R7 odd base dword
    send(17'h00123, 19'h7ffff, 0, 3);   // R5 index ignored
    send(17'h1ffff, 19'h7ffff, 1, 3);   // R6 wrap
    send(17'h1fffe, 12, 1, 0);          // R6 wrap byte
    // R9: stall output, then drain and refill
    in_valid = 1; in_word = 17'h00042; in_index = 3; in_idx_en = 1; in_size = 2'd2;
    out_ready = 0;
    step();
    in_word = 17'h00043;
    repeat (3) step();
    out_ready = 1;
    step();
    in_valid = 0;
    step();
    // random traffic with throttled consumer
    for (int i = 0; i < 3000; i++) begin
      if (!in_valid || m_acc) begin
        in_valid = ($urandom_range(0, 3) != 0);
        in_word = (ADDR_W-2)'($urandom);
        in_index = IDX_W'($urandom);
        in_idx_en = ($urandom_range(0, 4) != 0);
        in_size = 2'($urandom_range(0, 3));
      end
      out_ready = ($urandom_range(0, 2) != 0);
      step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule